// File: doc/BRIEF.md
# Interlaced Half-Line Vertical Counter

This block keeps the vertical position of a video raster. It counts half scanlines, not whole lines, so one field of either television standard fits the same counter whether or not the display is interlaced. An external timing stage supplies a single-cycle `hl_tick` once per half line. That is about every 31.78 µs for NTSC and every 32 µs for PAL. The block advances on each tick.

The counter is 12 bits wide. The low 11 bits hold the half-line position inside the current field. Bit 11 identifies the field: 0 is the upper field and 1 is the lower field. When a field ends, the field identity flips and the position restarts at zero. On that tick the block also emits a field-done pulse.

A programmable compare value lets software request a vertical interrupt at a chosen half line. When the position reaches that value, the value is nonzero and interrupts are enabled, the block emits a one-cycle interrupt pulse. The pulse comes out in the same cycle as the new count.

Top module: `hl_vcount`

## Requirements
- R1: After reset, `vcount` is 0x000, `lower_field` is 0 (upper field), and `vint_pulse` and `field_done` are 0.
- R2: In a cycle with `hl_tick` low, `vcount` keeps its value and both pulse outputs are 0 in the following cycle.
- R3: On a tick where the incremented low 11 bits stay below the field limit, the low 11 bits of `vcount` increase by exactly one and bit 11 is unchanged. The new value is visible in the cycle after the tick.
- R4: The field limit is 525 when `std_pal` is 0 (NTSC) and 625 when `std_pal` is 1 (PAL). On a tick where the incremented low 11 bits reach or exceed the limit, the field flips and `vcount` reloads to 0x800 if the new field is lower, or to 0x000 if it is upper.
- R5: `lower_field` always equals bit 11 of `vcount`.
- R6: `field_done` is a one-cycle pulse that appears together with the reloaded count on every field wrap, and at no other time.
- R7: `vint_pulse` is a one-cycle pulse that appears together with the new count when the new low 11 bits equal `vint_cmp`, `vint_cmp` is nonzero and `vint_en` is 1. `vint_cmp` and `vint_en` are sampled on the tick.
- R8: A `vint_cmp` of zero never produces an interrupt, including on field wraps where the position returns to zero.
- R9: With `vint_en` at 0, no interrupt pulse is produced even when the compare value matches.
- R10: A change of `std_pal` applies at the next tick. If the position is already at or above the new limit, that tick wraps the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | One-cycle strobe per half scanline |
| std_pal | input | 1 | 0 selects NTSC (525 half lines per field), 1 selects PAL (625) |
| vint_cmp | input | 11 | Half-line position that triggers the vertical interrupt |
| vint_en | input | 1 | Video interrupt enable |
| vcount | output | 12 | Bit 11 marks the lower field; bits 10:0 hold the half-line position |
| lower_field | output | 1 | 1 while the lower field is being drawn |
| vint_pulse | output | 1 | One-cycle vertical interrupt pulse |
| field_done | output | 1 | One-cycle pulse on each field wrap |

## Verification
The bench runs both standards through two complete wraps each. This catches a design that wraps one half line early or late, or that compares with `>` where `>=` is needed. It also catches a design that leaves bit 11 set after the lower field ends.

The compare value is set to a mid-field position, and separately to zero across a wrap. A design that raises the interrupt one cycle late would fail the first case. A design that fires when a zero compare meets the wrapped position would fail the second.

Finally, the standard is switched from PAL to NTSC while the position sits above 525. A design that tests for equality instead of "at or above" would then run past the limit and never wrap.

// File: rtl/hl_vcount.sv
module hl_vcount #(
  parameter int CNT_W       = 12,
  parameter int NTSC_HALVES = 525,
  parameter int PAL_HALVES  = 625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hl_tick,
  input  logic             std_pal,
  input  logic [CNT_W-2:0] vint_cmp,
  input  logic             vint_en,
  output logic [CNT_W-1:0] vcount,
  output logic             lower_field,
  output logic             vint_pulse,
  output logic             field_done
);
  localparam int LOW_W = CNT_W - 1;

  logic [LOW_W-1:0] pos_inc, limit;
  logic [CNT_W-1:0] vcount_d;
  logic             wrap, hit;

  assign pos_inc  = vcount[LOW_W-1:0] + 1'b1;
  assign limit    = std_pal ? LOW_W'(PAL_HALVES) : LOW_W'(NTSC_HALVES);
  assign wrap     = pos_inc >= limit;
  assign vcount_d = wrap ? {~vcount[CNT_W-1], {LOW_W{1'b0}}}
                         : {vcount[CNT_W-1], pos_inc};
  assign hit      = vint_en && (vint_cmp != '0) && (vcount_d[LOW_W-1:0] == vint_cmp);
  assign lower_field = vcount[CNT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcount     <= '0;
      vint_pulse <= 1'b0;
      field_done <= 1'b0;
    end else begin
      vint_pulse <= hl_tick && hit;
      field_done <= hl_tick && wrap;
      if (hl_tick) vcount <= vcount_d;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hl_tick |=> (vcount == $past(vcount)) && !vint_pulse && !field_done);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hl_tick |=> (vcount[LOW_W-1:0] == '0) ||
                ((vcount[LOW_W-1:0] == LOW_W'($past(vcount[LOW_W-1:0]) + 1'b1)) &&
                 (vcount[CNT_W-1] == $past(vcount[CNT_W-1]))));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> (vcount[LOW_W-1:0] == '0) && (vcount[CNT_W-1] != $past(vcount[CNT_W-1])));

  // R7
  vint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vint_pulse |-> (vcount[LOW_W-1:0] == $past(vint_cmp)) && $past(vint_en) &&
                   (vcount[LOW_W-1:0] != '0));

  // R5
  field_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lower_field == vcount[CNT_W-1]);
endmodule

// File: tb/hl_vcount_bench.sv
module hl_vcount_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hl_tick = 1'b0;
  logic        std_pal = 1'b0;
  logic [10:0] vint_cmp = '0;
  logic        vint_en = 1'b0;
  logic [11:0] vcount;
  logic        lower_field, vint_pulse, field_done;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";
  int m_pos = 0, m_fld = 0, m_vint = 0, m_fd = 0;

  always #5 clk = ~clk;

  hl_vcount u_hl_vcount (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .std_pal(std_pal),
    .vint_cmp(vint_cmp), .vint_en(vint_en), .vcount(vcount),
    .lower_field(lower_field), .vint_pulse(vint_pulse), .field_done(field_done)
  );

  task automatic check(string t, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int lim, nxt;
    m_vint = 0; m_fd = 0;
    if (!rst_n) begin
      m_pos = 0; m_fld = 0;
    end else if (hl_tick) begin
      lim = std_pal ? 625 : 525;
      nxt = m_pos + 1;
      if (nxt >= lim) begin
        m_fld = 1 - m_fld; m_pos = 0; m_fd = 1;
      end else m_pos = nxt;
      if (vint_en && vint_cmp != 0 && m_pos == vint_cmp) m_vint = 1;
    end
  endtask

  task automatic cyc(bit t);
    hl_tick = t;
    @(posedge clk);
    model_edge();
    #1;
    check(tag, vcount, m_fld * 2048 + m_pos, "vcount");
    check(tag, vint_pulse, m_vint, "vint_pulse");
    check(tag, field_done, m_fd, "field_done");
    check("R5", lower_field, vcount[11], "lower_field");
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1);
      for (int g = 0; g < gap; g++) cyc(1'b0);
    end
  endtask

  task automatic ticks_to(int pos);
    while (m_pos != pos) cyc(1'b1);
  endtask

  int fd_seen, vint_seen;

  initial begin
    repeat (3) cyc(1'b0);
    tag = "R1";
    check("R1", vcount, 0, "reset vcount");
    check("R1", lower_field, 0, "reset field");
    rst_n = 1'b1;
    cyc(1'b0);

    tag = "R2";
    vint_en = 1'b1; vint_cmp = 11'd0;
    for (int i = 0; i < 8; i++) begin vint_cmp = 11'(i * 3); cyc(1'b0); end

    tag = "R3";
    vint_cmp = 11'd0;
    ticks(40, 0);
    ticks(20, 2);
    check("R3", vcount, 60, "position after 60 ticks");

    tag = "R4";
    std_pal = 1'b0;
    ticks_to(524);
    cyc(1'b1);
    check("R4", vcount, 12'h800, "NTSC wrap to lower");
    check("R6", field_done, 1, "field_done on NTSC wrap");
    cyc(1'b0);
    check("R6", field_done, 0, "field_done one cycle");
    ticks_to(524);
    cyc(1'b1);
    check("R4", vcount, 12'h000, "NTSC wrap to upper");
    std_pal = 1'b1;
    ticks_to(624);
    cyc(1'b1);
    check("R4", vcount, 12'h800, "PAL wrap to lower");
    ticks_to(624);
    cyc(1'b1);
    check("R4", vcount, 12'h000, "PAL wrap to upper");

    tag = "R7";
    vint_cmp = 11'd100; vint_en = 1'b1;
    ticks_to(99);
    cyc(1'b1);
    check("R7", vint_pulse, 1, "interrupt at compare");
    cyc(1'b0);
    check("R7", vint_pulse, 0, "interrupt one cycle");

    tag = "R9";
    vint_en = 1'b0; vint_seen = 0;
    ticks_to(99);
    cyc(1'b1);
    check("R9", vint_pulse, 0, "disabled interrupt");

    tag = "R8";
    vint_en = 1'b1; vint_cmp = 11'd0; vint_seen = 0;
    ticks_to(624);
    cyc(1'b1);
    check("R8", vint_pulse, 0, "zero compare at wrap");
    ticks(10, 1);

    tag = "R10";
    std_pal = 1'b1;
    ticks_to(600);
    std_pal = 1'b0;
    fd_seen = m_fld;
    cyc(1'b1);
    check("R10", vcount[10:0], 0, "wrap after standard switch");
    check("R10", field_done, 1, "field_done after standard switch");
    ticks(30, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule